// File: doc/BRIEF.md
# Byte-to-Ten-Bit Line Encoder with Disparity Override

This block turns one byte per clock into a 10-bit DC-balanced code group following the standard 8B/10B line code. A control flag marks the byte as a control character rather than data. The encoder tracks the running disparity itself and presents it on an output. A bad control-character request raises an error flag, and the block then sends a comma in its place.

Two override inputs come with each byte. They let the user change the running disparity before that byte is encoded. With them, comma runs of a chosen polarity can be built, for example two positive commas followed by two negative ones. A bypass input turns encoding off. The same two override pins then become the top two bits of a raw 10-bit character, and the byte fills the lower eight bits. Results are registered and appear one clock after the inputs.

Top module: `linecode_enc`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `codeOut` = 0, `kErr` = 0 and `rdOut` = 0. The value 0 means negative running disparity and 1 means positive.
- R2: With `isCtrl` = 0, `dispMode` = 0, `dispValue` = 0 and `bypassEn` = 0, the byte is encoded as data character D.x.y. Here x = `dataIn[4:0]` and y = `dataIn[7:5]`. The code group is placed with bit a at `codeOut[9]`, then b c d e i f g h, and j at `codeOut[0]`. This includes the alternate .7 form after D17/D18/D20 at negative disparity and after D11/D13/D14 at positive disparity.
- R3: With `isCtrl` = 1, the twelve legal control characters are encoded in the polarity set by the running disparity. They are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7.
- R4: With `isCtrl` = 1 and any other byte, `kErr` is 1 on the next cycle. The output is K28.5 in the polarity of the effective disparity, and the running disparity is updated as for that K28.5.
- R5: Override code {`dispMode`,`dispValue`} = 00 encodes with the current running disparity. The disparity after each code group carries into the next one.
- R6: Override code 01 encodes the byte with the inverse of the current running disparity.
- R7: Override code 10 encodes with negative disparity, and code 11 encodes with positive disparity, whatever the current state.
- R8: With `bypassEn` = 1, the output is {`dispMode`, `dispValue`, `dataIn[7:0]`} with `dispMode` at bit 9. `kErr` is 0 and the running disparity is unchanged.
- R9: Each output reflects the inputs sampled at the previous rising edge, so the latency is exactly one cycle.
- R10: `rdOut` shows the running disparity left by the last code group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Byte to encode (HGF EDCBA) |
| isCtrl | input | 1 | Encode as a control character |
| dispMode | input | 1 | Override code, upper bit; raw bit 9 when in bypass |
| dispValue | input | 1 | Override code, lower bit; raw bit 8 when in bypass |
| bypassEn | input | 1 | Pass the raw 10-bit character through |
| codeOut | output | 10 | Code group, bit a at bit 9 |
| rdOut | output | 1 | Running disparity (1 = positive) |
| kErr | output | 1 | The last control request was illegal |

## Verification
Most stimulus runs as one chained sequence, so every code group also tests the disparity left by the one before it. Data bytes are chosen so that each branch of the code tables is taken at least once. The set covers balanced and unbalanced 6-bit blocks, the D7 and D.x.3 special cases, and the primary and alternate .7 forms at both polarities. These cases tell apart a complement decision that uses the entry disparity from one that uses the disparity between the two sub-blocks. All twelve legal commas are covered, together with illegal control bytes, a four-comma pattern with inversion on the second and fourth, and forced polarities. Bypass vectors place an illegal control byte on the pins to show that the error check and the disparity state are both idle in that mode.

// File: rtl/linecode_pkg.sv
package linecode_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = BYTE_W + 2;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned HI_W   = BYTE_W - LO_W;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hBC;  // K28.5

  typedef struct packed {
    logic rdUse;     // disparity used for this byte
    logic ctrlChar;  // encode as control character
    logic kBad;      // illegal control request
    logic bypass;    // raw passthrough
  } encCtrl_t;

  // 5b/6b code (abcdei) at negative disparity.
  function automatic logic [5:0] sixNeg(input logic [LO_W-1:0] x, input logic k);
    logic [5:0] c;
    case (x)
      5'd0:  c = 6'b100111; 5'd1:  c = 6'b011101; 5'd2:  c = 6'b101101;
      5'd3:  c = 6'b110001; 5'd4:  c = 6'b110101; 5'd5:  c = 6'b101001;
      5'd6:  c = 6'b011001; 5'd7:  c = 6'b111000; 5'd8:  c = 6'b111001;
      5'd9:  c = 6'b100101; 5'd10: c = 6'b010101; 5'd11: c = 6'b110100;
      5'd12: c = 6'b001101; 5'd13: c = 6'b101100; 5'd14: c = 6'b011100;
      5'd15: c = 6'b010111; 5'd16: c = 6'b011011; 5'd17: c = 6'b100011;
      5'd18: c = 6'b010011; 5'd19: c = 6'b110010; 5'd20: c = 6'b001011;
      5'd21: c = 6'b101010; 5'd22: c = 6'b011010; 5'd23: c = 6'b111010;
      5'd24: c = 6'b110011; 5'd25: c = 6'b100110; 5'd26: c = 6'b010110;
      5'd27: c = 6'b110110; 5'd28: c = k ? 6'b001111 : 6'b001110;
      5'd29: c = 6'b101110; 5'd30: c = 6'b011110;
      default: c = 6'b101011;
    endcase
    return c;
  endfunction

  // 3b/4b code (fghj) for data when the middle disparity is negative.
  function automatic logic [3:0] fourData(input logic [HI_W-1:0] y, input logic alt);
    logic [3:0] c;
    case (y)
      3'd0: c = 4'b1011; 3'd1: c = 4'b1001; 3'd2: c = 4'b0101; 3'd3: c = 4'b1100;
      3'd4: c = 4'b1101; 3'd5: c = 4'b1010; 3'd6: c = 4'b0110;
      default: c = alt ? 4'b0111 : 4'b1110;
    endcase
    return c;
  endfunction

  // 3b/4b code for control characters when the middle disparity is negative.
  function automatic logic [3:0] fourCtrl(input logic [HI_W-1:0] y);
    logic [3:0] c;
    case (y)
      3'd0: c = 4'b1011; 3'd1: c = 4'b0110; 3'd2: c = 4'b1010; 3'd3: c = 4'b1100;
      3'd4: c = 4'b1101; 3'd5: c = 4'b0101; 3'd6: c = 4'b1001;
      default: c = 4'b0111;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import linecode_pkg::*;
(
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              isCtrl,
  input  logic              dispMode,
  input  logic              dispValue,
  input  logic              bypassEn,
  input  logic              rdState,
  output encCtrl_t          ctrl
);
  logic [LO_W-1:0] xPart;
  logic [HI_W-1:0] yPart;
  logic            legalK;

  assign xPart = dataIn[LO_W-1:0];
  assign yPart = dataIn[BYTE_W-1:LO_W];

  always_comb begin
    legalK = (xPart == 5'd28) ||
             ((yPart == 3'd7) && ((xPart == 5'd23) || (xPart == 5'd27) ||
                                  (xPart == 5'd29) || (xPart == 5'd30)));
    ctrl.bypass   = bypassEn;
    ctrl.ctrlChar = isCtrl & ~bypassEn;
    ctrl.kBad     = isCtrl & ~bypassEn & ~legalK;
    case ({dispMode, dispValue})
      2'b00:   ctrl.rdUse = rdState;
      2'b01:   ctrl.rdUse = ~rdState;
      2'b10:   ctrl.rdUse = 1'b0;
      default: ctrl.rdUse = 1'b1;
    endcase
  end
endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import linecode_pkg::*;
(
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              dispMode,
  input  logic              dispValue,
  input  logic              rdState,
  input  encCtrl_t          ctrl,
  output logic [CODE_W-1:0] codeNext,
  output logic              rdNext
);
  logic [BYTE_W-1:0] useByte;
  logic [LO_W-1:0]   x;
  logic [HI_W-1:0]   y;
  logic              kChar, unbal6, unbal4, midRd, altSeven, flip6, flip4;
  logic [5:0]        six0, six;
  logic [3:0]        four0, four;

  always_comb begin
    useByte  = ctrl.kBad ? FILL_BYTE : dataIn;
    kChar    = ctrl.ctrlChar;
    x        = useByte[LO_W-1:0];
    y        = useByte[BYTE_W-1:LO_W];
    six0     = sixNeg(x, kChar);
    unbal6   = ($countones(six0) != 3);
    flip6    = ctrl.rdUse & (unbal6 | (!kChar && x == 5'd7));
    six      = flip6 ? ~six0 : six0;
    midRd    = ctrl.rdUse ^ unbal6;
    altSeven = (!midRd && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
               ( midRd && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    four0    = kChar ? fourCtrl(y) : fourData(y, altSeven);
    unbal4   = ($countones(four0) != 2);
    flip4    = midRd & (kChar | unbal4 | (y == 3'd3));
    four     = flip4 ? ~four0 : four0;
    if (ctrl.bypass) begin
      codeNext = {dispMode, dispValue, dataIn};
      rdNext   = rdState;
    end else begin
      codeNext = {six, four};
      rdNext   = midRd ^ unbal4;
    end
  end
endmodule

// File: rtl/linecode_enc.sv
module linecode_enc
  import linecode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              isCtrl,
  input  logic              dispMode,
  input  logic              dispValue,
  input  logic              bypassEn,
  output logic [CODE_W-1:0] codeOut,
  output logic              rdOut,
  output logic              kErr
);
  encCtrl_t          ctrl;
  logic [CODE_W-1:0] codeNext;
  logic              rdNext;

  lc_ctrl ctrl_i (
    .dataIn(dataIn), .isCtrl(isCtrl), .dispMode(dispMode), .dispValue(dispValue),
    .bypassEn(bypassEn), .rdState(rdOut), .ctrl(ctrl)
  );

  lc_datapath dp_i (
    .dataIn(dataIn), .dispMode(dispMode), .dispValue(dispValue), .rdState(rdOut),
    .ctrl(ctrl), .codeNext(codeNext), .rdNext(rdNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      codeOut <= '0;
      rdOut   <= 1'b0;
      kErr    <= 1'b0;
    end else begin
      codeOut <= codeNext;
      rdOut   <= rdNext;
      kErr    <= ctrl.kBad;
    end
  end
endmodule

// File: rtl/linecode_enc_chk.sv
module linecode_enc_chk
  import linecode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] dataIn,
  input logic              isCtrl,
  input logic              dispMode,
  input logic              dispValue,
  input logic              bypassEn,
  input logic [CODE_W-1:0] codeOut,
  input logic              rdOut,
  input logic              kErr
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (codeOut == '0 && !rdOut && !kErr));

  a_r8_bypass_raw: assert property (@(posedge clk) disable iff (rst)
    bypassEn |=> codeOut == $past({dispMode, dispValue, dataIn}));

  a_r8_bypass_rd_hold: assert property (@(posedge clk) disable iff (rst)
    bypassEn |=> (rdOut == $past(rdOut) && !kErr));

  a_r4_kerr_comma: assert property (@(posedge clk) disable iff (rst)
    kErr |-> (codeOut == 10'b0011111010 || codeOut == 10'b1100000101));

  a_r2_weight: assert property (@(posedge clk) disable iff (rst)
    !bypassEn |=> ($countones(codeOut) >= 4 && $countones(codeOut) <= 6));

  a_r10_rd_follows_weight: assert property (@(posedge clk) disable iff (rst)
    (!bypassEn && !dispMode && !dispValue) |=>
      (($countones(codeOut) == 5) ? (rdOut == $past(rdOut)) : (rdOut != $past(rdOut))));
endmodule

bind linecode_enc linecode_enc_chk chk_i (.*);

// File: tb/linecode_enc_tb_top.sv
module linecode_enc_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dataIn;
  logic       isCtrl, dispMode, dispValue, bypassEn;
  logic [9:0] codeOut;
  logic       rdOut, kErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  linecode_enc dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .isCtrl(isCtrl), .dispMode(dispMode),
    .dispValue(dispValue), .bypassEn(bypassEn), .codeOut(codeOut), .rdOut(rdOut), .kErr(kErr)
  );

  // {data, ctrl, mode, value, bypass, code, rd, kerr}
  localparam int NV = 29;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00,1'b0,1'b0,1'b0,1'b0,10'b1001110100,1'b0,1'b0}, // D0.0 -
    {8'hBC,1'b1,1'b0,1'b0,1'b0,10'b0011111010,1'b1,1'b0}, // K28.5 -
    {8'hB5,1'b0,1'b0,1'b0,1'b0,10'b1010101010,1'b1,1'b0}, // D21.5 +
    {8'hBC,1'b1,1'b0,1'b0,1'b0,10'b1100000101,1'b0,1'b0}, // K28.5 +
    {8'hF7,1'b0,1'b0,1'b0,1'b0,10'b1110100001,1'b0,1'b0}, // D23.7 - primary
    {8'hF1,1'b0,1'b0,1'b0,1'b0,10'b1000110111,1'b1,1'b0}, // D17.7 - alternate
    {8'hEB,1'b0,1'b0,1'b0,1'b0,10'b1101001000,1'b0,1'b0}, // D11.7 + alternate
    {8'h63,1'b0,1'b0,1'b0,1'b0,10'b1100011100,1'b0,1'b0}, // D3.3 -
    {8'hFC,1'b1,1'b0,1'b0,1'b0,10'b0011111000,1'b0,1'b0}, // K28.7 -
    {8'hF7,1'b1,1'b0,1'b0,1'b0,10'b1110101000,1'b0,1'b0}, // K23.7 -
    {8'hFB,1'b1,1'b0,1'b0,1'b0,10'b1101101000,1'b0,1'b0}, // K27.7 -
    {8'hFE,1'b1,1'b0,1'b0,1'b0,10'b0111101000,1'b0,1'b0}, // K30.7 -
    {8'hFD,1'b1,1'b0,1'b0,1'b0,10'b1011101000,1'b0,1'b0}, // K29.7 -
    {8'h00,1'b0,1'b1,1'b1,1'b0,10'b0110001011,1'b1,1'b0}, // force + D0.0
    {8'h27,1'b0,1'b1,1'b0,1'b0,10'b1110001001,1'b0,1'b0}, // force - D7.1
    {8'h07,1'b0,1'b0,1'b0,1'b0,10'b1110001011,1'b1,1'b0}, // D7.0 -
    {8'h07,1'b0,1'b0,1'b0,1'b0,10'b0001110100,1'b0,1'b0}, // D7.0 +
    {8'h00,1'b1,1'b0,1'b0,1'b0,10'b0011111010,1'b1,1'b1}, // illegal K
    {8'h3C,1'b1,1'b0,1'b0,1'b0,10'b1100000110,1'b0,1'b0}, // K28.1 +
    {8'hA5,1'b0,1'b1,1'b0,1'b1,10'b1010100101,1'b0,1'b0}, // bypass
    {8'h3C,1'b1,1'b0,1'b1,1'b1,10'b0100111100,1'b0,1'b0}, // bypass, ctrl set
    {8'hBC,1'b1,1'b0,1'b0,1'b0,10'b0011111010,1'b1,1'b0}, // comma run 1
    {8'hBC,1'b1,1'b0,1'b1,1'b0,10'b0011111010,1'b1,1'b0}, // comma run 2 inv
    {8'hBC,1'b1,1'b0,1'b0,1'b0,10'b1100000101,1'b0,1'b0}, // comma run 3
    {8'hBC,1'b1,1'b0,1'b1,1'b0,10'b1100000101,1'b0,1'b0}, // comma run 4 inv
    {8'h00,1'b0,1'b0,1'b1,1'b0,10'b0110001011,1'b1,1'b0}, // invert D0.0
    {8'hFC,1'b1,1'b0,1'b0,1'b0,10'b1100000111,1'b1,1'b0}, // K28.7 +
    {8'h5D,1'b1,1'b0,1'b0,1'b0,10'b1100000101,1'b0,1'b1}, // illegal K at +
    {8'h01,1'b1,1'b1,1'b1,1'b0,10'b1100000101,1'b0,1'b1}  // illegal K, force +
  };

  task automatic check(input string tag, input logic [9:0] gotC, input logic [9:0] expC,
                       input logic gotR, input logic expR, input logic gotK, input logic expK);
    checks++;
    if (gotC !== expC || gotR !== expR || gotK !== expK) begin
      fails++;
      $display("FAIL %s: code=%b rd=%b kErr=%b expected code=%b rd=%b kErr=%b",
               tag, gotC, gotR, gotK, expC, expR, expK);
    end
  endtask

  task automatic apply(input logic [23:0] v);
    {dataIn, isCtrl, dispMode, dispValue, bypassEn} = v[23:12];
  endtask

  function automatic string tagOf(input logic [23:0] v);
    if (v[12])                return "R8 bypass, R9";
    if (v[0])                 return "R4 illegal ctrl, R10";
    if (v[14])                return "R7 forced, R10";
    if (v[13])                return "R6 inverted, R10";
    if (v[15])                return "R3 ctrl char, R5/R10";
    return "R2 data char, R5/R10";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; apply(24'h0);
    repeat (3) @(negedge clk);
    check("R1 reset", codeOut, 10'b0, rdOut, 1'b0, kErr, 1'b0);
    rst = 1'b0;

    // R9: input driven now must not show until after the next rising edge
    apply(VEC[1]);
    #2 check("R9 before edge", codeOut, 10'b0, rdOut, 1'b0, kErr, 1'b0);
    @(negedge clk);
    check("R9 after edge", codeOut, 10'b0011111010, rdOut, 1'b1, kErr, 1'b0);

    // R1: reset restores negative disparity
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", codeOut, 10'b0, rdOut, 1'b0, kErr, 1'b0);
    rst = 1'b0;

    // vector table, chained running disparity
    apply(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(tagOf(VEC[i]), codeOut, VEC[i][11:2], rdOut, VEC[i][1], kErr, VEC[i][0]);
      if (i + 1 < NV) apply(VEC[i+1]);
    end

    // R1: reset while an illegal control byte is presented clears kErr
    apply({8'h00,1'b1,1'b0,1'b0,1'b0,12'h0});
    @(negedge clk);
    check("R4 illegal before reset", codeOut, 10'b0011111010, rdOut, 1'b1, kErr, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears error", codeOut, 10'b0, rdOut, 1'b0, kErr, 1'b0);
    rst = 1'b0;
    apply(VEC[0]);
    @(negedge clk);
    check("R1 negative after reset, R2", codeOut, 10'b1001110100, rdOut, 1'b0, kErr, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule